// File: doc/BRIEF.md
# Decimal Adjust Unit

This unit repairs an accumulator value after ordinary binary arithmetic so that it again holds valid binary-coded decimal digits. The accumulator is a word made of a high byte and a low byte. A single command picks one of six corrections:

- two forms for packed digits, one after addition and one after subtraction;
- two forms for unpacked digits, one after addition and one after subtraction;
- a split of the low byte into tens and units after a multiply;
- a recombination of tens and units into one binary byte before a divide.

The digit corrections use the incoming auxiliary-carry (AF) and carry (CF) flags and finish in a single cycle. The split runs a restoring divide-by-radix, one quotient bit per cycle. The recombination runs a shift-and-add multiply-by-radix, one multiplier bit per cycle. Because of these two sequential forms, the unit reports `busy` and raises a one-cycle `done` pulse when each command ends.

A command is offered by holding `start` high with `op`, `ax_in`, `af_in` and `cf_in` valid. It is accepted on a rising edge while `busy` is low. The operands and flags are captured at that edge, so they may change afterwards. Results appear on `ax_out`, `af_out` and `cf_out` together with `done`, and stay there until the next command completes. The digit width is half of `BYTE_W`, and `RADIX` is the decimal base (10 by default).

Top module: `decadj_unit`

## Requirements
- R1: After reset `ax_out`, `af_out`, `cf_out`, `busy` and `done` are all 0.
- R2: Op code 0 (packed add fix), for the low byte L:
  - Step 1: if L[3:0] > 9 or AF=1, add 06h to L and set AF_out=1. Otherwise L is unchanged and AF_out=0.
  - Step 2: if the step-1 value exceeds 9Fh, or CF=1, or step 1 carried out of the byte, add 60h and set CF_out=1. Otherwise CF_out=0.
  - The high byte is unchanged. Example: L=81h with AF=1 becomes 87h.
- R3: Op code 1 (packed subtract fix) follows the same two steps as R2, but subtracts 06h and 60h instead of adding them, and a borrow out of step 1 takes the place of the carry. The high byte is unchanged.
- R4: Op code 2 (unpacked add fix), with condition C = (L[3:0] > 9 or AF=1):
  - If C holds: add 06h to L, increment the high byte modulo 256, and set AF_out and CF_out to 1.
  - If C does not hold: clear AF_out and CF_out.
  - In both cases L[7:4] is cleared.
- R5: Op code 3 (unpacked subtract fix) uses the same condition C. If C holds: subtract 06h from L, decrement the high byte modulo 256, and set AF_out and CF_out to 1. If C does not hold: clear both flags. In both cases L[7:4] is cleared.
- R6: Op code 4 (split) sets the high byte to L / 10 and the low byte to L mod 10. Example: 3Fh gives 06h and 03h.
- R7: Op code 5 (combine) sets the low byte to (H*10 + L) mod 256 and the high byte to 0, where H is the incoming high byte.
- R8: Op codes 6 and 7 return the captured word and flags unchanged.
- R9: `done` is high for one cycle per accepted command, and `busy` is high from acceptance until the edge that raises `done`. Counting rising edges from the accepting edge (inclusive) to the edge that raises `done`:
  - ops 0–3, 6 and 7: 1 edge;
  - op 4: BYTE_W+1 edges (9 by default);
  - op 5: radix bit count + 1 edges (5 by default).
- R10: A `start` seen while `busy` is high is ignored. It produces no `done` and does not change the result of the command in flight.
- R11: For ops 4 and 5, `af_out` and `cf_out` equal the flags captured at acceptance. Changes to any input after acceptance do not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command request, accepted when `busy` is low |
| op | input | 3 | Command code, 0 to 7 (see R2–R8) |
| ax_in | input | 2*BYTE_W | Accumulator word, high byte in the upper half |
| af_in | input | 1 | Incoming auxiliary-carry flag |
| cf_in | input | 1 | Incoming carry flag |
| ax_out | output | 2*BYTE_W | Corrected accumulator word |
| af_out | output | 1 | Resulting auxiliary-carry flag |
| cf_out | output | 1 | Resulting carry flag |
| busy | output | 1 | A multi-cycle command is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with its default parameters: BYTE_W=8 and RADIX=10. With an 8-bit low byte, every input value can be swept together with all four flag combinations for each digit correction, and every dividend can be swept for the split. The combine form is swept over all 256 high-byte values, so results that wrap modulo 256 are exercised. The default widths also fix the latencies at 9 and 5 edges, which the bench measures for every command, along with an ignored `start` issued in the middle of a split.

// File: rtl/decadj_pkg.sv
// Package: shared command codes and control states for the decimal adjust unit.
// Assumes a 3-bit command field; codes 6 and 7 are reserved pass-through.
package decadj_pkg;

    typedef enum logic [2:0] {
        OP_PADD  = 3'd0,
        OP_PSUB  = 3'd1,
        OP_UADD  = 3'd2,
        OP_USUB  = 3'd3,
        OP_SPLIT = 3'd4,
        OP_COMB  = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } adj_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIV  = 2'd1,
        ST_MUL  = 2'd2
    } adj_st_e;

endpackage

// File: rtl/decadj_nibfix.sv
// Module: combinational digit correction for one direction (add or subtract).
// IS_SUB selects the direction. It produces both the packed result and the
// unpacked result from the same first-digit step.
// Assumes RADIX <= 2**(BYTE_W/2), so that one digit fits in half a byte.
module decadj_nibfix #(
    parameter int BYTE_W = 8,
    parameter int RADIX  = 10,
    parameter bit IS_SUB = 1'b0
) (
    input  logic [BYTE_W-1:0] al_i,
    input  logic [BYTE_W-1:0] ah_i,
    input  logic              af_i,
    input  logic              cf_i,
    output logic [BYTE_W-1:0] pk_al_o,
    output logic              pk_af_o,
    output logic              pk_cf_o,
    output logic [BYTE_W-1:0] up_al_o,
    output logic [BYTE_W-1:0] up_ah_o,
    output logic              up_fl_o
);
    localparam int NIB_W = BYTE_W / 2;
    localparam logic [NIB_W-1:0]  LO_LIM  = NIB_W'(RADIX - 1);
    localparam logic [BYTE_W-1:0] LO_FIX  = BYTE_W'((1 << NIB_W) - RADIX);
    localparam logic [BYTE_W-1:0] HI_FIX  = LO_FIX << NIB_W;
    localparam logic [BYTE_W-1:0] HI_LIM  = BYTE_W'((RADIX << NIB_W) - 1);
    localparam logic [BYTE_W-1:0] LO_MASK = BYTE_W'((1 << NIB_W) - 1);

    logic              fix_lo;
    logic              fix_hi;
    logic              lo_carry;
    logic [BYTE_W:0]   lo_sum;
    logic [BYTE_W-1:0] step1;
    logic [BYTE_W-1:0] hi_res;
    logic [BYTE_W-1:0] ah_res;

    // Low digit needs correction when it is out of range or AF reports a carry.
    always_comb fix_lo = (al_i[NIB_W-1:0] > LO_LIM) | af_i;

    generate
        if (IS_SUB) begin : g_sub
            // Subtract variant: borrow appears in the extra top bit.
            always_comb lo_sum = {1'b0, al_i} - {1'b0, LO_FIX};
            always_comb hi_res = step1 - HI_FIX;
            always_comb ah_res = ah_i - BYTE_W'(1);
        end else begin : g_add
            // Add variant: carry appears in the extra top bit.
            always_comb lo_sum = {1'b0, al_i} + {1'b0, LO_FIX};
            always_comb hi_res = step1 + HI_FIX;
            always_comb ah_res = ah_i + BYTE_W'(1);
        end
    endgenerate

    // First step: apply the low-digit correction if needed.
    always_comb begin
        step1    = fix_lo ? lo_sum[BYTE_W-1:0] : al_i;
        lo_carry = fix_lo & lo_sum[BYTE_W];
    end

    // Second step (packed only): correct the high digit.
    always_comb fix_hi = (step1 > HI_LIM) | cf_i | lo_carry;

    // Drive the packed results.
    always_comb begin
        pk_al_o = fix_hi ? hi_res : step1;
        pk_af_o = fix_lo;
        pk_cf_o = fix_hi;
    end

    // Drive the unpacked results: keep one digit, move the carry into the high byte.
    always_comb begin
        up_al_o = step1 & LO_MASK;
        up_ah_o = fix_lo ? ah_res : ah_i;
        up_fl_o = fix_lo;
    end

endmodule

// File: rtl/decadj_div10.sv
// Module: sequential restoring divider by the constant RADIX.
// Produces one quotient bit per cycle, most significant bit first.
// 'go' loads the dividend. 'fin' is high during the last step, and
// quot_o/rem_o then show that step's final values.
// Assumes 'go' is only raised while the divider is idle.
module decadj_div10 #(
    parameter int BYTE_W = 8,
    parameter int RADIX  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [BYTE_W-1:0] dividend,
    output logic              fin,
    output logic [BYTE_W-1:0] quot_o,
    output logic [BYTE_W-1:0] rem_o
);
    localparam int RAD_W = $clog2(RADIX + 1);
    localparam int CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
    localparam logic [RAD_W:0]   DIVISOR = (RAD_W + 1)'(RADIX);
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] shreg_q;
    logic [BYTE_W-1:0] quo_q;
    logic [RAD_W-1:0]  rem_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              run_q;
    logic [RAD_W:0]    trial;
    logic              fits;
    logic [RAD_W:0]    diff;
    logic [RAD_W-1:0]  rem_nx;
    logic [BYTE_W-1:0] quo_nx;

    // One restoring step: bring in the next dividend bit and subtract the divisor if it fits.
    always_comb begin
        trial  = {rem_q, shreg_q[BYTE_W-1]};
        fits   = trial >= DIVISOR;
        diff   = trial - DIVISOR;
        rem_nx = fits ? diff[RAD_W-1:0] : trial[RAD_W-1:0];
        quo_nx = {quo_q[BYTE_W-2:0], fits};
    end

    // Expose the final values during the last step.
    always_comb begin
        fin    = run_q && (cnt_q == LAST);
        quot_o = quo_nx;
        rem_o  = {{(BYTE_W - RAD_W){1'b0}}, rem_nx};
    end

    // Iteration registers: load on go, then shift once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            quo_q   <= '0;
            rem_q   <= '0;
            cnt_q   <= '0;
            run_q   <= 1'b0;
        end else if (go) begin
            shreg_q <= dividend;
            quo_q   <= '0;
            rem_q   <= '0;
            cnt_q   <= '0;
            run_q   <= 1'b1;
        end else if (run_q) begin
            shreg_q <= shreg_q << 1;
            quo_q   <= quo_nx;
            rem_q   <= rem_nx;
            cnt_q   <= cnt_q + CNT_W'(1);
            if (fin) begin
                run_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/decadj_mul10.sv
// Module: sequential multiply by the constant RADIX, plus an addend.
// Uses shift-and-add over the bits of RADIX, least significant bit first.
// The accumulator starts at the addend, and the result wraps at BYTE_W bits.
// 'fin' is high during the last step, and prod_o then shows the final sum.
module decadj_mul10 #(
    parameter int BYTE_W = 8,
    parameter int RADIX  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [BYTE_W-1:0] mcand,
    input  logic [BYTE_W-1:0] addend,
    output logic              fin,
    output logic [BYTE_W-1:0] prod_o
);
    localparam int RAD_W = $clog2(RADIX + 1);
    localparam int CNT_W = (RAD_W > 2) ? $clog2(RAD_W) : 1;
    localparam logic [RAD_W-1:0] MULT = RAD_W'(RADIX);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RAD_W - 1);

    logic [BYTE_W-1:0] acc_q;
    logic [BYTE_W-1:0] mc_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              run_q;
    logic [BYTE_W-1:0] acc_nx;

    // Add the shifted multiplicand when the current multiplier bit is set.
    always_comb begin
        acc_nx = MULT[cnt_q] ? (acc_q + mc_q) : acc_q;
        fin    = run_q && (cnt_q == LAST);
        prod_o = acc_nx;
    end

    // Iteration registers: load on go, then one multiplier bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            mc_q  <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (go) begin
            acc_q <= addend;
            mc_q  <= mcand;
            cnt_q <= '0;
            run_q <= 1'b1;
        end else if (run_q) begin
            acc_q <= acc_nx;
            mc_q  <= mc_q << 1;
            cnt_q <= cnt_q + CNT_W'(1);
            if (fin) begin
                run_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/decadj_unit.sv
// Module: top level of the decimal adjust unit.
// Accepts one command when idle and captures its operands at that edge.
// Digit fixes and reserved codes finish on the accepting edge.
// Split and combine hand off to the sequential divider or multiplier.
// Results are registered and held until the next command completes.
module decadj_unit
    import decadj_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int RADIX  = 10,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [WORD_W-1:0] ax_in,
    input  logic              af_in,
    input  logic              cf_in,
    output logic [WORD_W-1:0] ax_out,
    output logic              af_out,
    output logic              cf_out,
    output logic              busy,
    output logic              done
);
    logic [BYTE_W-1:0] ah;
    logic [BYTE_W-1:0] al;
    adj_op_e           op_e;
    adj_st_e           state_q;
    logic              accept;
    logic              div_go;
    logic              mul_go;
    logic              div_fin;
    logic              mul_fin;
    logic [BYTE_W-1:0] div_quot;
    logic [BYTE_W-1:0] div_rem;
    logic [BYTE_W-1:0] mul_prod;
    logic              hold_af_q;
    logic              hold_cf_q;
    logic [WORD_W-1:0] ax_q;
    logic              af_q;
    logic              cf_q;
    logic              done_q;

    // Digit-fix results: index 0 is the add direction, index 1 the subtract direction.
    logic [BYTE_W-1:0] pk_al [2];
    logic              pk_af [2];
    logic              pk_cf [2];
    logic [BYTE_W-1:0] up_al [2];
    logic [BYTE_W-1:0] up_ah [2];
    logic              up_fl [2];

    // Split the word and decode the command.
    always_comb begin
        ah     = ax_in[WORD_W-1:BYTE_W];
        al     = ax_in[BYTE_W-1:0];
        op_e   = adj_op_e'(op);
        accept = start && (state_q == ST_IDLE);
        div_go = accept && (op_e == OP_SPLIT);
        mul_go = accept && (op_e == OP_COMB);
    end

    generate
        for (genvar d = 0; d < 2; d++) begin : g_dir
            decadj_nibfix #(
                .BYTE_W (BYTE_W),
                .RADIX  (RADIX),
                .IS_SUB (d == 1)
            ) u_fix (
                .al_i    (al),
                .ah_i    (ah),
                .af_i    (af_in),
                .cf_i    (cf_in),
                .pk_al_o (pk_al[d]),
                .pk_af_o (pk_af[d]),
                .pk_cf_o (pk_cf[d]),
                .up_al_o (up_al[d]),
                .up_ah_o (up_ah[d]),
                .up_fl_o (up_fl[d])
            );
        end
    endgenerate

    decadj_div10 #(
        .BYTE_W (BYTE_W),
        .RADIX  (RADIX)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (al),
        .fin      (div_fin),
        .quot_o   (div_quot),
        .rem_o    (div_rem)
    );

    decadj_mul10 #(
        .BYTE_W (BYTE_W),
        .RADIX  (RADIX)
    ) u_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (mul_go),
        .mcand  (ah),
        .addend (al),
        .fin    (mul_fin),
        .prod_o (mul_prod)
    );

    // Control state, result registers and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            ax_q      <= '0;
            af_q      <= 1'b0;
            cf_q      <= 1'b0;
            done_q    <= 1'b0;
            hold_af_q <= 1'b0;
            hold_cf_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        unique case (op_e)
                            OP_PADD: begin
                                ax_q   <= {ah, pk_al[0]};
                                af_q   <= pk_af[0];
                                cf_q   <= pk_cf[0];
                                done_q <= 1'b1;
                            end
                            OP_PSUB: begin
                                ax_q   <= {ah, pk_al[1]};
                                af_q   <= pk_af[1];
                                cf_q   <= pk_cf[1];
                                done_q <= 1'b1;
                            end
                            OP_UADD: begin
                                ax_q   <= {up_ah[0], up_al[0]};
                                af_q   <= up_fl[0];
                                cf_q   <= up_fl[0];
                                done_q <= 1'b1;
                            end
                            OP_USUB: begin
                                ax_q   <= {up_ah[1], up_al[1]};
                                af_q   <= up_fl[1];
                                cf_q   <= up_fl[1];
                                done_q <= 1'b1;
                            end
                            OP_SPLIT: begin
                                hold_af_q <= af_in;
                                hold_cf_q <= cf_in;
                                state_q   <= ST_DIV;
                            end
                            OP_COMB: begin
                                hold_af_q <= af_in;
                                hold_cf_q <= cf_in;
                                state_q   <= ST_MUL;
                            end
                            default: begin
                                ax_q   <= ax_in;
                                af_q   <= af_in;
                                cf_q   <= cf_in;
                                done_q <= 1'b1;
                            end
                        endcase
                    end
                end
                ST_DIV: begin
                    if (div_fin) begin
                        ax_q    <= {div_quot, div_rem};
                        af_q    <= hold_af_q;
                        cf_q    <= hold_cf_q;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                ST_MUL: begin
                    if (mul_fin) begin
                        ax_q    <= {{BYTE_W{1'b0}}, mul_prod};
                        af_q    <= hold_af_q;
                        cf_q    <= hold_cf_q;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the ports from the registers.
    always_comb begin
        ax_out = ax_q;
        af_out = af_q;
        cf_out = cf_q;
        done   = done_q;
        busy   = (state_q != ST_IDLE);
    end

endmodule

// File: rtl/decadj_chk.sv
// Module: assertion checker for decadj_unit, attached with bind.
// Records the last accepted command code and checks how the ports relate over time.
module decadj_chk
    import decadj_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int RADIX  = 10,
    localparam int WORD_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [2:0]        op,
    input logic              busy,
    input logic              done,
    input logic [WORD_W-1:0] ax_out,
    input logic              af_out,
    input logic              cf_out
);
    localparam int NIB_W = BYTE_W / 2;
    localparam logic [BYTE_W-1:0] QMAX  = BYTE_W'(((1 << BYTE_W) - 1) / RADIX);
    localparam logic [BYTE_W-1:0] RMAX  = BYTE_W'(RADIX - 1);

    adj_op_e last_op_q;

    // Remember the code of the command most recently accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_op_q <= OP_RSV7;
        end else if (start && !busy) begin
            last_op_q <= adj_op_e'(op);
        end
    end

    // R9: done never appears while a command is still running
    a_r9_no_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    // R9: the end of busy always comes with done
    a_r9_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10: while busy, the result registers hold still
    a_r10_result_stable_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> ($stable(ax_out) && $stable(af_out) && $stable(cf_out)));

    // R6: the split yields a quotient and remainder in range
    a_r6_split_range: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && last_op_q == OP_SPLIT) |->
            (ax_out[BYTE_W-1:0] <= RMAX && ax_out[WORD_W-1:BYTE_W] <= QMAX));

    // R7: the combine clears the high byte
    a_r7_comb_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && last_op_q == OP_COMB) |-> (ax_out[WORD_W-1:BYTE_W] == '0));

    // R4, R5: unpacked fixes leave one digit and equal AF/CF
    a_r4_unpacked_one_digit: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (last_op_q == OP_UADD || last_op_q == OP_USUB)) |->
            (ax_out[BYTE_W-1:NIB_W] == '0 && af_out == cf_out));

endmodule

bind decadj_unit decadj_chk #(
    .BYTE_W (BYTE_W),
    .RADIX  (RADIX)
) u_decadj_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op     (op),
    .busy   (busy),
    .done   (done),
    .ax_out (ax_out),
    .af_out (af_out),
    .cf_out (cf_out)
);

// File: tb/tb_decadj_unit.sv
`timescale 1ns/1ps
// Bench: sweeps every command over its input space at BYTE_W=8, RADIX=10.
// Expected values are computed arithmetically from the requirements.
module tb_decadj_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [15:0] ax_in = 16'h0;
    logic        af_in = 1'b0;
    logic        cf_in = 1'b0;
    logic [15:0] ax_out;
    logic        af_out;
    logic        cf_out;
    logic        busy;
    logic        done;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    decadj_unit #(.BYTE_W(8), .RADIX(10)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .ax_in(ax_in),
        .af_in(af_in), .cf_in(cf_in), .ax_out(ax_out), .af_out(af_out),
        .cf_out(cf_out), .busy(busy), .done(done)
    );

    // Record one check; print a FAIL line with actual and expected values on mismatch.
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected result, returned as {cf, af, ax}.
    function automatic logic [17:0] model(input logic [2:0] o, input logic [15:0] ax,
                                          input logic af, input logic cf);
        logic [7:0] h;
        logic [7:0] l;
        logic [8:0] s;
        logic       a;
        logic       c;
        logic       c1;
        h = ax[15:8];
        l = ax[7:0];
        a = 1'b0;
        c = 1'b0;
        c1 = 1'b0;
        case (o)
            3'd0, 3'd1: begin
                if (l[3:0] > 4'd9 || af) begin
                    s  = (o == 3'd0) ? ({1'b0, l} + 9'd6) : ({1'b0, l} - 9'd6);
                    c1 = s[8];
                    l  = s[7:0];
                    a  = 1'b1;
                end
                if (l > 8'h9F || cf || c1) begin
                    l = (o == 3'd0) ? (l + 8'h60) : (l - 8'h60);
                    c = 1'b1;
                end
            end
            3'd2, 3'd3: begin
                if (l[3:0] > 4'd9 || af) begin
                    l = (o == 3'd2) ? (l + 8'd6) : (l - 8'd6);
                    h = (o == 3'd2) ? (h + 8'd1) : (h - 8'd1);
                    a = 1'b1;
                    c = 1'b1;
                end
                l = l & 8'h0F;
            end
            3'd4: begin
                h = l / 8'd10;
                l = l % 8'd10;
                a = af;
                c = cf;
            end
            3'd5: begin
                l = 8'((32'(h) * 10 + 32'(l)) & 32'hFF);
                h = 8'h00;
                a = af;
                c = cf;
            end
            default: begin
                a = af;
                c = cf;
            end
        endcase
        return {c, a, h, l};
    endfunction

    function automatic int exp_lat(input logic [2:0] o);
        if (o == 3'd4) return 9;
        if (o == 3'd5) return 5;
        return 1;
    endfunction

    // Issue one command, scramble the inputs after acceptance, and check result, latency and pulse width.
    task automatic run_op(input logic [2:0] o, input logic [15:0] ax, input logic af,
                          input logic cf, input string req);
        int n;
        logic [17:0] e;
        e = model(o, ax, af, cf);
        @(negedge clk);
        start = 1'b1; op = o; ax_in = ax; af_in = af; cf_in = cf;
        @(posedge clk);
        n = 1;
        @(negedge clk);
        start = 1'b0; ax_in = ~ax; af_in = ~af; cf_in = ~cf; op = ~o;
        while (!done && n < 40) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        chk({cf_out, af_out, ax_out} == e, req, {14'd0, cf_out, af_out, ax_out}, {14'd0, e});
        chk(n == exp_lat(o), "R9 latency", n, exp_lat(o));
        @(posedge clk);
        @(negedge clk);
        chk(!done, "R9 done one cycle", {31'd0, done}, 32'd0);
    endtask

    initial begin
        #750000;
        n_chk++;
        n_fail++;
        $display("FAIL R9 watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state right after reset
        chk(ax_out == 16'h0 && !af_out && !cf_out && !busy && !done, "R1 reset",
            {13'd0, busy, done, cf_out, af_out, ax_out}, 32'd0);
        rst_n = 1'b1;

        // R2: worked case 81h with AF set becomes 87h
        run_op(3'd0, 16'h0081, 1'b1, 1'b0, "R2 worked case");

        // R2, R3, R4, R5: full sweep of the low byte with all flag pairs
        for (int o = 0; o < 4; o++) begin
            for (int v = 0; v < 256; v++) begin
                for (int f = 0; f < 4; f++) begin
                    logic [7:0] l8;
                    l8 = 8'(v);
                    case (o)
                        0: run_op(3'd0, {l8 ^ 8'h5A, l8}, f[0], f[1], "R2 packed add");
                        1: run_op(3'd1, {l8 ^ 8'hA5, l8}, f[0], f[1], "R3 packed sub");
                        2: run_op(3'd2, {8'hFF - l8, l8}, f[0], f[1], "R4 unpacked add");
                        default: run_op(3'd3, {l8, l8}, f[0], f[1], "R5 unpacked sub");
                    endcase
                end
            end
        end

        // R6, R11: split every dividend, with flags passing through
        for (int v = 0; v < 256; v++) begin
            logic [7:0] l8;
            l8 = 8'(v);
            run_op(3'd4, {~l8, l8}, l8[0], l8[1], "R6 R11 split");
        end

        // R7, R11: combine every high byte, including wrapping sums
        for (int v = 0; v < 256; v++) begin
            logic [7:0] h8;
            h8 = 8'(v);
            run_op(3'd5, {h8, 8'(h8 * 3 + 1)}, h8[1], h8[0], "R7 R11 combine");
        end

        // R8: reserved codes pass the word and flags through
        for (int v = 0; v < 16; v++) begin
            run_op(3'd6, 16'(v * 4099), v[0], v[1], "R8 reserved 6");
            run_op(3'd7, 16'(v * 7919), v[1], v[0], "R8 reserved 7");
        end

        // R10: a start issued during a split is ignored
        begin
            int n;
            @(negedge clk);
            start = 1'b1; op = 3'd4; ax_in = 16'h00FF; af_in = 1'b1; cf_in = 1'b0;
            @(posedge clk);
            n = 1;
            @(negedge clk);
            start = 1'b0;
            @(posedge clk); n++;
            @(posedge clk); n++;
            @(negedge clk);
            start = 1'b1; op = 3'd0; ax_in = 16'h1234; af_in = 1'b0; cf_in = 1'b1;
            @(posedge clk); n++;
            @(negedge clk);
            start = 1'b0;
            while (!done && n < 40) begin
                @(posedge clk);
                n++;
                @(negedge clk);
            end
            chk({cf_out, af_out, ax_out} == {1'b0, 1'b1, 16'h1905}, "R10 split result kept",
                {14'd0, cf_out, af_out, ax_out}, {14'd0, 1'b0, 1'b1, 16'h1905});
            chk(n == 9, "R10 latency unchanged", n, 9);
            for (int k = 0; k < 4; k++) begin
                @(posedge clk);
                @(negedge clk);
                chk(!done && ax_out == 16'h1905, "R10 no extra done",
                    {15'd0, done, ax_out}, {16'd0, 16'h1905});
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule